// File: doc/BRIEF.md
# Sparse Token Readout with Neighbour Collection

This block keeps one event mark per channel for a 64-channel front end. While the chip acquires data, each channel's peak-found strobe sets that channel's mark. A per-channel mask can exclude a channel. When neighbour collection is on, the channels next to a hit are marked as well. The neighbour relation reaches across the chip boundary on both ends through a pair of neighbour trigger lines. An option also makes channels 7 and 56 neighbours of each other. The first real peak raises an event flag, which tells the outside world that the chip has data to read out.

In readout mode, a chain of chips passes a token from one to the next. When the token arrives here, the block lists the marked channels in ascending order, one on each readout clock. It never spends a clock on an empty channel, and it clears each mark as it serves that channel. The 6-bit channel address is enabled only while this chip holds the token. After the last address, the block drives a token pulse to the next chip that lasts more than one clock. Each bidirectional neighbour trigger line is split here into a receive half and a drive half, and the pad logic outside the block combines them. The address bus is modelled the same way: a value plus an output enable.

Top module: `sparse_token_readout`

## Requirements
- R1: After reset: no channel is marked; `flag`, `addr_oe`, `tok_out`, `edge_lo_out` and `edge_hi_out` are 0; `addr` is 0.
- R2: While `acq_en` is 1, a clock edge that sees `peak_found[i]` high with `chan_mask[i]` low sets the mark of channel i. Marks accumulate over cycles. When `acq_en` is 0, `peak_found` has no effect on the marks.
- R3: `flag` goes high on the edge after the first unmasked peak seen in acquisition. It stays high until the edge on which this chip passes the token on. Marks set only through neighbours do not raise it.
- R4: A channel whose mask bit is 1 in a given cycle is not marked in that cycle, whether by its own peak or as a neighbour. Its own peak also marks no neighbours.
- R5: With `nbr_en` = 1, an unmasked hit on channel i also marks channels i-1 and i+1, where those exist.
- R6: With `nbr_en` and `bridge_en` both 1, a hit on channel 7 marks channel 56, and a hit on 56 marks 7. With `bridge_en` = 0, no such link exists.
- R7: With `nbr_en` = 1 in acquisition, an unmasked hit on channel 0 drives `edge_lo_out` high for exactly the next cycle. Channel 63 does the same with `edge_hi_out`. A high `edge_lo_in` or `edge_hi_in` marks channel 0 or channel 63 respectively. With `nbr_en` = 0, the edge inputs are ignored and the edge outputs stay 0.
- R8: In readout (`acq_en` = 0), the edge that sees `tok_in` go from 0 to 1 sets `addr_oe` to 1 and puts the lowest marked channel index on `addr`.
- R9: On each later edge, `addr` moves to the next higher marked channel, with no idle cycle between them. Every marked channel is presented exactly once.
- R10: On the edge after the last address, `addr_oe` falls and `tok_out` rises. `tok_out` stays high for exactly TOK_W cycles (2 by default). If no channel is marked, `tok_out` rises on the very edge that sees the rising `tok_in`.
- R11: Whenever this chip does not hold the token, including during acquisition, `addr_oe` is 0 and `addr` reads 0.
- R12: A channel's mark is cleared when that channel is served. A second token that arrives with no acquisition in between is passed straight on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout and acquisition clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | 1 = acquisition mode, 0 = readout mode |
| peak_found | input | 64 | Per-channel peak-found strobes |
| chan_mask | input | 64 | 1 excludes the channel from marking |
| nbr_en | input | 1 | Enables neighbour collection |
| bridge_en | input | 1 | Makes channels 7 and 56 neighbours |
| edge_lo_in | input | 1 | Neighbour trigger received at the channel-0 side |
| edge_hi_in | input | 1 | Neighbour trigger received at the channel-63 side |
| tok_in | input | 1 | Token from the previous chip |
| flag | output | 1 | Event flag |
| addr | output | 6 | Address of the channel being served, 0 when not driven |
| addr_oe | output | 1 | Address output enable (high only while holding the token) |
| tok_out | output | 1 | Token to the next chip, TOK_W cycles wide |
| edge_lo_out | output | 1 | Neighbour trigger driven at the channel-0 side |
| edge_hi_out | output | 1 | Neighbour trigger driven at the channel-63 side |

## Verification
The assertions assume that `tok_in` rises only once per readout and only while no earlier token is still being served or passed on. They also assume that the chip stays in readout for the whole service of a token, so an address sequence is never cut off by a return to acquisition. The bench keeps within these limits. It drops `acq_en` before it raises the token, and it holds `tok_in` high for two clocks and then low. It waits until `tok_out` has ended before it starts the next acquisition round. Masks, strobes, the neighbour options and the edge inputs change freely from cycle to cycle during acquisition, since the block must handle any mix of them.

// File: rtl/srd_pkg.sv
package srd_pkg;
    typedef enum logic [1:0] {
        TK_IDLE  = 2'd0,
        TK_SERVE = 2'd1,
        TK_PASS  = 2'd2
    } tok_state_e;
endpackage

// File: rtl/srd_nbr_mark.sv
// Per-channel set vector: own hit plus neighbour spreading, gated by the mask.
module srd_nbr_mark #(
    parameter int NCH   = 64,
    parameter int BR_A  = 7,
    parameter int BR_B  = 56
) (
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] chan_mask,
    input  logic           nbr_en,
    input  logic           bridge_en,
    input  logic           edge_lo,
    input  logic           edge_hi,
    output logic [NCH-1:0] set_vec
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic lo_n, up_n, br_n;
        if (i == 0) begin : g_lo_edge
            assign lo_n = edge_lo;
        end else begin : g_lo_int
            assign lo_n = hit[i-1];
        end
        if (i == NCH-1) begin : g_up_edge
            assign up_n = edge_hi;
        end else begin : g_up_int
            assign up_n = hit[i+1];
        end
        if (i == BR_A) begin : g_br_a
            assign br_n = bridge_en & hit[BR_B];
        end else if (i == BR_B) begin : g_br_b
            assign br_n = bridge_en & hit[BR_A];
        end else begin : g_br_none
            assign br_n = 1'b0;
        end
        assign set_vec[i] = ~chan_mask[i] & (hit[i] | (nbr_en & (lo_n | up_n | br_n)));
    end
endmodule

// File: rtl/srd_first_pick.sv
// Lowest-index set bit finder.
module srd_first_pick #(
    parameter int NCH = 64,
    parameter int AW  = 6
) (
    input  logic [NCH-1:0] vec,
    output logic           any,
    output logic [AW-1:0]  idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = NCH-1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
    import srd_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int TOK_W = 2,
    parameter int BR_A  = 7,
    parameter int BR_B  = 56
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acq_en,
    input  logic [NCH-1:0]           peak_found,
    input  logic [NCH-1:0]           chan_mask,
    input  logic                     nbr_en,
    input  logic                     bridge_en,
    input  logic                     edge_lo_in,
    input  logic                     edge_hi_in,
    input  logic                     tok_in,
    output logic                     flag,
    output logic [$clog2(NCH)-1:0]   addr,
    output logic                     addr_oe,
    output logic                     tok_out,
    output logic                     edge_lo_out,
    output logic                     edge_hi_out
);
    localparam int AW = $clog2(NCH);
    localparam int CW = $clog2(TOK_W + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TOK_W - 1);

    typedef struct packed {
        logic [NCH-1:0] mark;
        logic           flag;
        tok_state_e     st;
        logic [AW-1:0]  addr;
        logic [CW-1:0]  cnt;
        logic           tok_in;
        logic           edge_lo;
        logic           edge_hi;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0] hit_w;
    logic [NCH-1:0] set_w;
    logic           pick_any;
    logic [AW-1:0]  pick_idx;
    logic           tok_rise;

    assign hit_w    = peak_found & ~chan_mask;
    assign tok_rise = tok_in & ~st_q.tok_in;

    srd_nbr_mark #(.NCH(NCH), .BR_A(BR_A), .BR_B(BR_B)) u_nbr (
        .hit       (hit_w),
        .chan_mask (chan_mask),
        .nbr_en    (nbr_en),
        .bridge_en (bridge_en),
        .edge_lo   (edge_lo_in),
        .edge_hi   (edge_hi_in),
        .set_vec   (set_w)
    );

    srd_first_pick #(.NCH(NCH), .AW(AW)) u_pick (
        .vec (st_q.mark),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tok_in  = tok_in;
        st_d.edge_lo = 1'b0;
        st_d.edge_hi = 1'b0;
        if (acq_en) begin
            st_d.mark    = st_q.mark | set_w;
            st_d.flag    = st_q.flag | (|hit_w);
            st_d.edge_lo = nbr_en & hit_w[0];
            st_d.edge_hi = nbr_en & hit_w[NCH-1];
            st_d.st      = TK_IDLE;
            st_d.cnt     = '0;
        end else begin
            case (st_q.st)
                TK_IDLE: begin
                    if (tok_rise) begin
                        if (pick_any) begin
                            st_d.st             = TK_SERVE;
                            st_d.addr           = pick_idx;
                            st_d.mark[pick_idx] = 1'b0;
                        end else begin
                            st_d.st   = TK_PASS;
                            st_d.cnt  = '0;
                            st_d.flag = 1'b0;
                        end
                    end
                end
                TK_SERVE: begin
                    if (pick_any) begin
                        st_d.addr           = pick_idx;
                        st_d.mark[pick_idx] = 1'b0;
                    end else begin
                        st_d.st   = TK_PASS;
                        st_d.cnt  = '0;
                        st_d.flag = 1'b0;
                    end
                end
                TK_PASS: begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.st  = TK_IDLE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.st = TK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mark: '0, flag: 1'b0, st: TK_IDLE, addr: '0, cnt: '0,
                      tok_in: 1'b0, edge_lo: 1'b0, edge_hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag        = st_q.flag;
    assign addr_oe     = (st_q.st == TK_SERVE);
    assign addr        = addr_oe ? st_q.addr : '0;
    assign tok_out     = (st_q.st == TK_PASS);
    assign edge_lo_out = st_q.edge_lo;
    assign edge_hi_out = st_q.edge_hi;

    logic [NCH-1:0] mark_q;
    assign mark_q = st_q.mark;

    p_oe_only_readout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acq_en |=> !addr_oe);

    p_no_oe_with_tok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_oe && tok_out));

    if (TOK_W >= 2) begin : g_wide_chk
        p_tok_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tok_out) |=> tok_out);
    end

    p_mask_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acq_en |=> ((mark_q & ~$past(mark_q) & $past(chan_mask)) == '0));

    p_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> !mark_q[addr]);

    p_ascending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && $past(addr_oe)) |-> (addr > $past(addr)));

    p_flag_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && (|(peak_found & ~chan_mask))) |=> flag);

    p_edge_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !nbr_en |=> (!edge_lo_out && !edge_hi_out));
endmodule

// File: tb/sparse_token_readout_test.sv
module sparse_token_readout_test;
    localparam int NCH   = 64;
    localparam int TOK_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acq_en = 1'b1;
    logic [NCH-1:0]  peak_found = '0;
    logic [NCH-1:0]  chan_mask = '0;
    logic            nbr_en = 1'b0;
    logic            bridge_en = 1'b0;
    logic            edge_lo_in = 1'b0;
    logic            edge_hi_in = 1'b0;
    logic            tok_in = 1'b0;
    logic            flag;
    logic [5:0]      addr;
    logic            addr_oe;
    logic            tok_out;
    logic            edge_lo_out;
    logic            edge_hi_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [NCH-1:0] exp_mark = '0;
    bit             exp_flag = 1'b0;

    always #5 clk = ~clk;

    sparse_token_readout #(.NCH(NCH), .TOK_W(TOK_W)) uut (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .peak_found(peak_found),
        .chan_mask(chan_mask), .nbr_en(nbr_en), .bridge_en(bridge_en),
        .edge_lo_in(edge_lo_in), .edge_hi_in(edge_hi_in), .tok_in(tok_in),
        .flag(flag), .addr(addr), .addr_oe(addr_oe), .tok_out(tok_out),
        .edge_lo_out(edge_lo_out), .edge_hi_out(edge_hi_out)
    );

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] spread(logic [NCH-1:0] hit, logic [NCH-1:0] msk,
                                              bit nb, bit br, bit elo, bit ehi);
        logic [NCH-1:0] s = '0;
        for (int i = 0; i < NCH; i++) begin
            bit lo = (i > 0) ? hit[i-1] : elo;
            bit up = (i < NCH-1) ? hit[i+1] : ehi;
            bit bv = (i == 7) ? hit[56] : ((i == 56) ? hit[7] : 1'b0);
            s[i] = !msk[i] && (hit[i] || (nb && (lo || up || (br && bv))));
        end
        return s;
    endfunction

    function automatic int nth_set(logic [NCH-1:0] v, int n);
        int k = 0;
        for (int i = 0; i < NCH; i++) begin
            if (v[i]) begin
                if (k == n) return i;
                k++;
            end
        end
        return -1;
    endfunction

    // One acquisition cycle; called at a falling edge, returns at the next.
    task automatic acq_cycle(logic [NCH-1:0] pk, logic [NCH-1:0] msk, bit nb, bit br, bit elo, bit ehi);
        logic [NCH-1:0] hit;
        acq_en = 1'b1; peak_found = pk; chan_mask = msk; nbr_en = nb; bridge_en = br;
        edge_lo_in = elo; edge_hi_in = ehi;
        hit = pk & ~msk;
        exp_mark |= spread(hit, msk, nb, br, elo, ehi);
        if (|hit) exp_flag = 1'b1;
        @(negedge clk);
        check(edge_lo_out == (nb && hit[0]), "R7", "edge_lo_out", 64'(edge_lo_out), 64'(nb && hit[0]));
        check(edge_hi_out == (nb && hit[NCH-1]), "R7", "edge_hi_out", 64'(edge_hi_out), 64'(nb && hit[NCH-1]));
        check(!addr_oe && addr == 0, "R11", "addr_oe/addr in acquisition", {57'd0, addr_oe, addr}, 64'd0);
        check(flag == exp_flag, "R3", "flag during acquisition", 64'(flag), 64'(exp_flag));
    endtask

    // Readout of the current marks; called at a falling edge.
    task automatic readout(string tag);
        int nexp = $countones(exp_mark);
        int nserv = 0;
        int tk_first = -1;
        int tk_len = 0;
        acq_en = 1'b0; peak_found = '0; edge_lo_in = 1'b0; edge_hi_in = 1'b0;
        @(negedge clk);
        check(flag == exp_flag, "R3", {tag, " flag before token"}, 64'(flag), 64'(exp_flag));
        // strobes during readout must not add marks
        peak_found = {$urandom(), $urandom()};
        chan_mask = '0;
        @(negedge clk);
        peak_found = '0;
        @(negedge clk);
        tok_in = 1'b1;
        for (int j = 1; j <= 80; j++) begin
            @(negedge clk);
            if (j == 2) tok_in = 1'b0;
            if (addr_oe) begin
                int e = nth_set(exp_mark, nserv);
                check(j == nserv + 1, "R9", {tag, " no gap in service"}, 64'(j), 64'(nserv + 1));
                check(int'(addr) == e, (nserv == 0) ? "R8" : "R9", {tag, " served address"},
                      64'(addr), 64'(e));
                nserv++;
            end else if (!tok_out) begin
                check(addr == 0, "R11", {tag, " addr idle"}, 64'(addr), 64'd0);
            end
            if (tok_out) begin
                if (tk_first < 0) tk_first = j;
                tk_len++;
            end
        end
        check(nserv == nexp, "R2", {tag, " number of served channels"}, 64'(nserv), 64'(nexp));
        check(tk_first == nexp + 1, "R10", {tag, " token out timing"}, 64'(tk_first), 64'(nexp + 1));
        check(tk_len == TOK_W, "R10", {tag, " token out width"}, 64'(tk_len), 64'(TOK_W));
        check(flag == 1'b0, "R3", {tag, " flag after pass"}, 64'(flag), 64'd0);
        exp_mark = '0;
        exp_flag = 1'b0;
    endtask

    function automatic logic [NCH-1:0] sparse64();
        return {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
    endfunction

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        check(!flag && !addr_oe && addr == 0 && !tok_out && !edge_lo_out && !edge_hi_out,
              "R1", "outputs in reset",
              {58'd0, flag, addr_oe, tok_out, edge_lo_out, edge_hi_out, |addr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!flag && !addr_oe && !tok_out, "R1", "outputs after reset",
              {61'd0, flag, addr_oe, tok_out}, 64'd0);

        // empty chip: token passes at once (R1 no marks, R10 empty pass)
        readout("R1_empty");

        // bridge on: hit 7 marks 6,7,8,56 (R6, R5)
        acq_cycle(64'd1 << 7, '0, 1'b1, 1'b1, 1'b0, 1'b0);
        check(exp_mark == ((64'd7 << 6) | (64'd1 << 56)), "R6", "bridge model", exp_mark, exp_mark);
        readout("R6_bridge_on");
        // bridge off: hit 56 marks 55,56,57 only
        acq_cycle(64'd1 << 56, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        readout("R6_bridge_off");

        // edges: hits on 0 and 63 drive edge outputs (R7)
        acq_cycle((64'd1 << 63) | 64'd1, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        readout("R7_edge_out");
        // incoming edge triggers only, no hits: marks 0 and 63, flag stays low (R7, R3)
        acq_cycle('0, '0, 1'b1, 1'b0, 1'b1, 1'b1);
        readout("R7_edge_in");
        // edge inputs ignored without neighbour enable (R7)
        acq_cycle(64'd1, '0, 1'b0, 1'b1, 1'b1, 1'b1);
        readout("R7_nbr_off");

        // masking: masked peak marks nothing; masked neighbour skipped (R4)
        acq_cycle(64'd1 << 10, 64'd1 << 10, 1'b1, 1'b0, 1'b0, 1'b0);
        acq_cycle(64'd1 << 11, 64'd1 << 12, 1'b1, 1'b0, 1'b0, 1'b0);
        readout("R4_mask");

        // every channel hit: 64 consecutive addresses (R9)
        acq_cycle('1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        readout("R9_all");

        // marks accumulate over cycles, then a second token passes straight (R2, R12)
        acq_cycle(64'd1 << 20, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        acq_cycle(64'd1 << 3, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        readout("R2_accum");
        readout("R12_second_token");

        // random rounds
        for (int r = 0; r < 40; r++) begin
            int ncyc = 1 + ($urandom() % 4);
            for (int c = 0; c < ncyc; c++) begin
                acq_cycle(sparse64(), sparse64(), 1'($urandom()), 1'($urandom()),
                          ($urandom() % 5) == 0, ($urandom() % 5) == 0);
            end
            readout("R5_random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule